// File: doc/BRIEF.md
# Regulator Power Sequencing Controller

This block steps a multiphase voltage regulator from power-on reset to regulated output. Each condition it reacts to arrives as a single-bit digital input: the controller-supply and driver-supply undervoltage comparators, the enable pin, the calibration-complete flag, driver readiness, the output over-voltage and under-voltage comparators, the droop current-limit comparator, a flag that says no processor is present, and a flag that says the commanded voltage code is valid. From these it drives four outputs: the current state, a regulator-ready flag, a power-stage drive enable and a select for the DAC target. The select picks either the boot voltage or the commanded code.

The block counts clock cycles for three timed phases: the calibration delay, the soft-start interval and the ramp interval. Each length is a parameter. The default calibration length is 3.5 ms at 250 MHz, and a testbench can shorten all three. The block separates its two output faults. An over-voltage is latched and clears only when enable drops or the controller supply is lost. An under-voltage clears by itself once the output recovers.

Top module: `vreg_seq_ctrl`

## Requirements
- R1: While rst_n is low the state output is 0 (power-on reset), and ready, drive_en and dac_vid are all 0. The state codes are: 0 reset, 1 disable, 2 calibrate, 3 drive off, 4 phase detect, 5 soft start, 6 ramp, 7 normal, 8 over-voltage fault, 9 under-voltage fault.
- R2: vcc_ok low at a clock edge puts the machine in state 0 from any state, and this rule outranks all others. From state 0 with vcc_ok high, the machine moves to state 1.
- R3: With vcc_ok high, en low moves any state other than 0 to state 1. In state 1, en high moves the machine to state 2.
- R4: Calibrate lasts at least CAL_CYC cycles. The machine leaves calibrate for state 3 at the first edge where it has spent at least CAL_CYC cycles there and cal_done is high. The cycle count restarts every time calibrate is entered.
- R5: State 3 moves to state 4 only at an edge where vccp_ok and drv_rdy are both high. State 4 moves to state 5 on the following edge unless a higher-priority rule applies.
- R6: Soft start lasts SS_CYC cycles and is followed by ramp. Ramp lasts RAMP_CYC cycles and is followed by normal. Each interval counts from its own entry.
- R7: In states 4, 5, 6, 7 and 9, ovp high moves the machine to state 8. State 8 is held until en or vcc_ok goes low.
- R8: In ramp or normal, uv high moves the machine to state 9. In state 9, uv low returns it to state 7. uv has no effect during soft start.
- R9: In states 5, 6, 7 and 9, ilim high, no_cpu high or vid_ok low moves the machine to state 3. This rule ranks below R7 and above R8.
- R10: drive_en is 1 in states 4, 5, 6, 7 and 9 and 0 in all other states. dac_vid is 0 (boot target) in soft start and 1 (commanded code) in states 6, 7 and 9. dac_vid is 0 in every other state.
- R11: ready is 1 exactly when the state output is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_ok | input | 1 | Controller supply above its undervoltage threshold |
| en | input | 1 | Regulator enable |
| cal_done | input | 1 | Calibration complete |
| vccp_ok | input | 1 | Driver supply above its undervoltage threshold |
| drv_rdy | input | 1 | Power-stage drivers ready |
| ovp | input | 1 | Output above the over-voltage threshold |
| uv | input | 1 | Output below the under-voltage threshold |
| ilim | input | 1 | Droop sense above the current limit |
| no_cpu | input | 1 | No processor present |
| vid_ok | input | 1 | Commanded voltage code is valid |
| state | output | 4 | Current state code |
| ready | output | 1 | Regulator ready |
| drive_en | output | 1 | Power-stage drive enable |
| dac_vid | output | 1 | DAC target select: 1 commanded code, 0 boot voltage |

## Verification
Every transition lands on the clock edge at which its inputs are sampled, so the new state code is visible one cycle after the stimulus. The bench changes inputs only at the falling edge. The reference model advances one step at each rising edge, and the outputs are compared at the next falling edge. ready, drive_en and dac_vid are decoded directly from the state register. They are due in the same cycle as the state code and are checked in that cycle. Timed phases are compared cycle by cycle against a bench counter that restarts on every state change, which confirms each interval's length to the exact edge.

// File: rtl/vreg_seq_ctrl.sv
module vreg_seq_ctrl #(
  parameter int CAL_CYC  = 875000,
  parameter int SS_CYC   = 1000,
  parameter int RAMP_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ok,
  input  logic       en,
  input  logic       cal_done,
  input  logic       vccp_ok,
  input  logic       drv_rdy,
  input  logic       ovp,
  input  logic       uv,
  input  logic       ilim,
  input  logic       no_cpu,
  input  logic       vid_ok,
  output logic [3:0] state,
  output logic       ready,
  output logic       drive_en,
  output logic       dac_vid
);

  localparam int MAXL = (CAL_CYC > SS_CYC) ?
                        ((CAL_CYC > RAMP_CYC) ? CAL_CYC : RAMP_CYC) :
                        ((SS_CYC > RAMP_CYC) ? SS_CYC : RAMP_CYC);
  localparam int CW = $clog2(MAXL) + 1;
  localparam logic [CW-1:0] CAL_END  = CW'(CAL_CYC - 1);
  localparam logic [CW-1:0] SS_END   = CW'(SS_CYC - 1);
  localparam logic [CW-1:0] RAMP_END = CW'(RAMP_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(MAXL - 1);

  typedef enum logic [3:0] {
    S_POR    = 4'd0,
    S_OFF    = 4'd1,
    S_CAL    = 4'd2,
    S_DRVOFF = 4'd3,
    S_PHASE  = 4'd4,
    S_SOFT   = 4'd5,
    S_RAMP   = 4'd6,
    S_RUN    = 4'd7,
    S_OVP    = 4'd8,
    S_UVP    = 4'd9
  } st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic fault, regulating;

  assign fault      = ilim | no_cpu | ~vid_ok;
  assign regulating = (st == S_SOFT) || (st == S_RAMP) || (st == S_RUN) || (st == S_UVP);

  always_comb begin
    st_nx = st;
    if (!vcc_ok)
      st_nx = S_POR;
    else if (st == S_POR)
      st_nx = S_OFF;
    else if (!en)
      st_nx = S_OFF;
    else begin
      unique case (st)
        S_OFF:    st_nx = S_CAL;
        S_CAL:    if (cnt >= CAL_END && cal_done) st_nx = S_DRVOFF;
        S_DRVOFF: if (vccp_ok && drv_rdy) st_nx = S_PHASE;
        S_OVP:    st_nx = S_OVP;
        default: begin
          if (ovp)
            st_nx = S_OVP;
          else if (regulating && fault)
            st_nx = S_DRVOFF;
          else begin
            case (st)
              S_PHASE: st_nx = S_SOFT;
              S_SOFT:  if (cnt >= SS_END) st_nx = S_RAMP;
              S_RAMP:  if (uv) st_nx = S_UVP;
                       else if (cnt >= RAMP_END) st_nx = S_RUN;
              S_RUN:   if (uv) st_nx = S_UVP;
              S_UVP:   if (!uv) st_nx = S_RUN;
              default: st_nx = S_POR;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_POR;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st)
        cnt <= '0;
      else if (cnt != CNT_TOP)
        cnt <= cnt + 1'b1;
    end
  end

  assign state    = st;
  assign ready    = (st == S_RUN);
  assign drive_en = (st == S_PHASE) || regulating;
  assign dac_vid  = (st == S_RAMP) || (st == S_RUN) || (st == S_UVP);

endmodule

// File: rtl/vreg_seq_ctrl_chk.sv
module vreg_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_ok,
  input logic       en,
  input logic       cal_done,
  input logic       vccp_ok,
  input logic       drv_rdy,
  input logic       ovp,
  input logic       uv,
  input logic [3:0] state,
  input logic       ready,
  input logic       drive_en,
  input logic       dac_vid
);

  assert_por_on_uvlo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> state == 4'd0);

  assert_disable_on_en_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_ok && !en && state != 4'd0) |=> state == 4'd1);

  assert_cal_exit_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd3 && $past(state) == 4'd2) |-> $past(cal_done));

  assert_phase_needs_driver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd4 && $past(state) == 4'd3) |-> $past(vccp_ok && drv_rdy));

  assert_ovp_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd8 && en && vcc_ok) |=> state == 4'd8);

  assert_uvp_exit_to_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd9 && vcc_ok && en && !ovp && !uv && $stable(state)) |-> ##1 (state == 4'd7 || state == 4'd3));

  assert_soft_start_boot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd5 |-> (drive_en && !dac_vid));

  assert_ready_driven_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (drive_en && dac_vid));

endmodule

bind vreg_seq_ctrl vreg_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .en(en), .cal_done(cal_done),
  .vccp_ok(vccp_ok), .drv_rdy(drv_rdy), .ovp(ovp), .uv(uv),
  .state(state), .ready(ready), .drive_en(drive_en), .dac_vid(dac_vid)
);

// File: tb/test_vreg_seq_ctrl.sv
module test_vreg_seq_ctrl;
  localparam int CAL  = 12;
  localparam int SS   = 5;
  localparam int RMP  = 4;

  logic clk = 0, rst_n = 0;
  logic vcc_ok = 0, en = 0, cal_done = 0, vccp_ok = 0, drv_rdy = 0;
  logic ovp = 0, uv = 0, ilim = 0, no_cpu = 0, vid_ok = 1;
  logic [3:0] state;
  logic ready, drive_en, dac_vid;

  int vectors = 0, errors = 0;
  logic [3:0] ms = 0;
  int mcnt = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  vreg_seq_ctrl #(.CAL_CYC(CAL), .SS_CYC(SS), .RAMP_CYC(RMP)) i_vreg_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .en(en), .cal_done(cal_done),
    .vccp_ok(vccp_ok), .drv_rdy(drv_rdy), .ovp(ovp), .uv(uv), .ilim(ilim),
    .no_cpu(no_cpu), .vid_ok(vid_ok), .state(state), .ready(ready),
    .drive_en(drive_en), .dac_vid(dac_vid)
  );

  function automatic logic exp_drive(logic [3:0] s);
    return s == 4 || s == 5 || s == 6 || s == 7 || s == 9;
  endfunction
  function automatic logic exp_vid(logic [3:0] s);
    return s == 6 || s == 7 || s == 9;
  endfunction

  task automatic model_step();
    logic [3:0] n = ms;
    logic flt = ilim | no_cpu | ~vid_ok;
    tag = "R2";
    if (!vcc_ok) n = 0;
    else if (ms == 0) n = 1;
    else if (!en) begin n = 1; tag = "R3"; end
    else if (ms == 1) begin n = 2; tag = "R3"; end
    else if (ms == 8) tag = "R7";
    else if (ms == 2) begin tag = "R4"; if (mcnt >= CAL-1 && cal_done) n = 3; end
    else if (ms == 3) begin tag = "R5"; if (vccp_ok && drv_rdy) n = 4; end
    else if (ovp) begin n = 8; tag = "R7"; end
    else if (ms != 4 && flt) begin n = 3; tag = "R9"; end
    else begin
      case (ms)
        4: begin n = 5; tag = "R5"; end
        5: begin tag = "R6"; if (mcnt >= SS-1) n = 6; end
        6: if (uv) begin n = 9; tag = "R8"; end
           else begin tag = "R6"; if (mcnt >= RMP-1) n = 7; end
        7: begin tag = "R8"; if (uv) n = 9; end
        9: begin tag = "R8"; if (!uv) n = 7; end
        default: n = 0;
      endcase
    end
    mcnt = (n != ms) ? 0 : mcnt + 1;
    ms = n;
  endtask

  task automatic chk(string t, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", t, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(tag, state, ms);
    chk("R11", ready, ms == 7);
    chk("R10 drive_en", drive_en, exp_drive(ms));
    chk("R10 dac_vid", dac_vid, exp_vid(ms));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic set_in(logic v, logic e, logic c, logic p, logic d,
                        logic o, logic u, logic l, logic nc, logic vo);
    vcc_ok = v; en = e; cal_done = c; vccp_ok = p; drv_rdy = d;
    ovp = o; uv = u; ilim = l; no_cpu = nc; vid_ok = vo;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(negedge clk);
    set_in(1, 1, 1, 1, 1, 0, 0, 0, 0, 1);
    @(negedge clk);
    tag = "R1";
    check_all();
    rst_n = 1;
    // clean bring-up: cal_done high early, R4 minimum stay
    repeat (CAL + SS + RMP + 8) cyc();
    chk("R11 reached normal", state, 7);
    // UVP and recovery R8
    uv = 1; cyc(); uv = 0; cyc();
    chk("R8 recovered", state, 7);
    // ILIM out of regulation R9
    ilim = 1; cyc(); ilim = 0;
    chk("R9 drive off", state, 3);
    repeat (2 + SS + RMP) cyc();
    // OVP latch R7 then hold, cleared by en low
    ovp = 1; cyc(); ovp = 0;
    repeat (5) cyc();
    chk("R7 latched", state, 8);
    en = 0; cyc(); en = 1;
    chk("R3 disable", state, 1);
    // calibration with late cal_done: R4
    cal_done = 0; repeat (CAL + 6) cyc();
    chk("R4 waiting on done", state, 2);
    cal_done = 1; cyc();
    chk("R4 exit", state, 3);
    // driver not ready R5
    vccp_ok = 0; repeat (3) cyc();
    chk("R5 hold drive off", state, 3);
    vccp_ok = 1; cyc();
    // supply loss R2
    vcc_ok = 0; cyc(); vcc_ok = 1;
    chk("R2 por", state, 0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      set_in(($urandom % 100) < 99, ($urandom % 100) < 98, ($urandom % 100) < 60,
             ($urandom % 100) < 85, ($urandom % 100) < 85, ($urandom % 1000) < 8,
             ($urandom % 100) < 10, ($urandom % 100) < 2, ($urandom % 1000) < 5,
             ($urandom % 100) < 99);
      cyc();
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule